// File: doc/BRIEF.md
# Programmable I/O Window Decoder

This block compares each I/O port address on the bus with two programmable windows. When a window claims the access, the block raises that window's hit line and one of two generic chip-select lines. Each window has four configuration registers: the high byte of a 16-bit base port, the low byte of that base port, a size byte, and a control byte. The control byte holds an enable bit, an overlap-permit bit and a 3-bit chip-select code. A window spans `size` consecutive ports, and the size must be a power of two. The window claims an address whose bits above log2(size) equal the same bits of the base port.

The platform's default bus decoder reports through `isa_claim` that it already owns the current address. A window without its overlap-permit bit yields to the default decoder. A window with the bit set takes the address anyway. When both windows are eligible, window 0 wins. The block then flags a conflict unless window 1 has its overlap-permit bit set. All decode outputs are combinational in the current address and strobes. The configuration registers are clocked and are reset by an active-low reset. The block passes no data stream, so every pin is a plain level and there is no valid/ready handshake.

Top module: `io_window_decoder`

## Requirements
- R1: After reset, each window reads back base high 0x00, base low 0x00, size 0x01 and control 0x05. In the control byte, the code is in bits 2:0, enable is bit 3 and overlap permit is bit 4.
- R2: Configuration index w*4+k selects window w. Register k is 0 = base bits 15:8, 1 = base bits 7:0, 2 = size, 3 = control. Control bits 7:5 are not stored and read as 0. A write to one window leaves the other window unchanged.
- R3: An enabled and valid window claims an address exactly when (addr & ~(size-1)) == (base & ~(size-1)), with size-1 zero-extended to 16 bits.
- R4: No hit, chip select or conflict occurs unless io_rd or io_wr is high, or for a window whose enable bit is 0.
- R5: A size value that is zero or not a power of two stops that window from ever hitting.
- R6: A chip-select code other than 3'b101 or 3'b110 stops that window from ever hitting.
- R7: Code 3'b101 drives cs_sel[0] and code 3'b110 drives cs_sel[1]. Only the winning window's line is driven, and cs_sel is 0 when no window hits.
- R8: While isa_claim is high, a window whose overlap-permit bit is 0 does not hit. A window with the bit set hits regardless of isa_claim.
- R9: When both windows are eligible, only win_hit[0] is raised. At most one win_hit bit is high.
- R10: conflict is high exactly when both windows are eligible and window 1's overlap-permit bit is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration registers |
| cfg_addr | input | 3 | Write index: window in bit 2, register in bits 1:0 |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | 3 | Readback index, same layout as cfg_addr |
| cfg_rdata | output | 8 | Readback data (combinational) |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| isa_claim | input | 1 | Default decoder owns this address |
| win_hit | output | 2 | Per-window hit after priority |
| cs_sel | output | 2 | Generic chip-select lines, active high |
| conflict | output | 1 | Both windows eligible with window 1 not permitted to overlap |

## Verification
The assertions check on every cycle the relations visible at the ports:
- at most one hit line and at most one chip-select line are high;
- a chip-select line is high exactly when some window hits;
- with no strobe there is no hit;
- a conflict always comes with a hit.

Only the bench's sweeps can show the parts that depend on the programmed state. These are the address match boundaries for each size, the suppression caused by a bad size or code, yielding to `isa_claim` as set by the overlap-permit bit, and the register layout and reset values. The bench sweeps every port address across several configurations and compares each one against an arithmetic model.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int IO_AW  = 16;
  localparam int BYTE_W = 8;
  localparam int NUM_CS = 2;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_CS0 = 3'b101;
  localparam logic [CODE_W-1:0] CODE_CS1 = 3'b110;
  localparam logic [BYTE_W-1:0] SIZE_RST = 8'h01;

  typedef struct packed {
    logic [IO_AW-1:0]  base;
    logic [BYTE_W-1:0] size;
    logic              ovl;
    logic              en;
    logic [CODE_W-1:0] code;
  } win_cfg_t;

  function automatic logic size_is_pow2(input logic [BYTE_W-1:0] s);
    return (s != '0) && ((s & (s - 1'b1)) == '0);
  endfunction
endpackage

// File: rtl/io_win_regs.sv
module io_win_regs
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int CFG_AW  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [CFG_AW-1:0]         waddr,
  input  logic [BYTE_W-1:0]         wdata,
  input  logic [CFG_AW-1:0]         raddr,
  output logic [BYTE_W-1:0]         rdata,
  output win_cfg_t [NUM_WIN-1:0]    cfg
);
  localparam int WSEL_W = CFG_AW - 2;

  logic [WSEL_W-1:0] wsel, rsel;
  assign wsel = waddr[CFG_AW-1:2];
  assign rsel = raddr[CFG_AW-1:2];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic hit_w;
    assign hit_w = we && (wsel == WSEL_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[w].base <= '0;
        cfg[w].size <= SIZE_RST;
        cfg[w].ovl  <= 1'b0;
        cfg[w].en   <= 1'b0;
        cfg[w].code <= CODE_CS0;
      end else if (hit_w) begin
        case (waddr[1:0])
          2'd0: cfg[w].base[IO_AW-1:BYTE_W] <= wdata;
          2'd1: cfg[w].base[BYTE_W-1:0]     <= wdata;
          2'd2: cfg[w].size                 <= wdata;
          default: begin
            cfg[w].ovl  <= wdata[4];
            cfg[w].en   <= wdata[3];
            cfg[w].code <= wdata[2:0];
          end
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (rsel == WSEL_W'(w)) begin
        case (raddr[1:0])
          2'd0: rdata = cfg[w].base[IO_AW-1:BYTE_W];
          2'd1: rdata = cfg[w].base[BYTE_W-1:0];
          2'd2: rdata = cfg[w].size;
          default: rdata = {3'b000, cfg[w].ovl, cfg[w].en, cfg[w].code};
        endcase
      end
    end
  end
endmodule

// File: rtl/io_win_match.sv
module io_win_match
  import iowin_pkg::*;
(
  input  win_cfg_t           cfg,
  input  logic [IO_AW-1:0]   addr,
  input  logic               access,
  input  logic               isa_claim,
  output logic               eligible,
  output logic [NUM_CS-1:0]  cs_vec
);
  logic [IO_AW-1:0] keep_mask;
  logic             size_ok, code_ok, in_range;

  assign keep_mask = ~{{(IO_AW-BYTE_W){1'b0}}, cfg.size - 1'b1};
  assign size_ok   = size_is_pow2(cfg.size);
  assign code_ok   = (cfg.code == CODE_CS0) || (cfg.code == CODE_CS1);
  assign in_range  = (addr & keep_mask) == (cfg.base & keep_mask);
  assign eligible  = access && cfg.en && size_ok && code_ok && in_range &&
                     (cfg.ovl || !isa_claim);
  assign cs_vec    = {cfg.code == CODE_CS1, cfg.code == CODE_CS0};
endmodule

// File: rtl/io_win_arb.sv
module io_win_arb
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic [NUM_WIN-1:0]             eligible,
  input  logic [NUM_WIN-1:0]             ovl,
  input  logic [NUM_WIN-1:0][NUM_CS-1:0] cs_vec,
  output logic [NUM_WIN-1:0]             hit,
  output logic [NUM_CS-1:0]              cs,
  output logic                           conflict
);
  always_comb begin
    logic taken;
    taken    = 1'b0;
    hit      = '0;
    cs       = '0;
    conflict = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (eligible[w]) begin
        if (!taken) begin
          hit[w] = 1'b1;
          cs     = cs_vec[w];
        end else if (!ovl[w]) begin
          conflict = 1'b1;
        end
        taken = 1'b1;
      end
    end
  end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  localparam int CFG_AW = $clog2(NUM_WIN) + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [BYTE_W-1:0]   cfg_wdata,
  input  logic [CFG_AW-1:0]   cfg_raddr,
  output logic [BYTE_W-1:0]   cfg_rdata,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic                io_rd,
  input  logic                io_wr,
  input  logic                isa_claim,
  output logic [NUM_WIN-1:0]  win_hit,
  output logic [NUM_CS-1:0]   cs_sel,
  output logic                conflict
);
  win_cfg_t [NUM_WIN-1:0]             cfg;
  logic     [NUM_WIN-1:0]             elig, ovl;
  logic     [NUM_WIN-1:0][NUM_CS-1:0] csv;
  logic                               access;

  assign access = io_rd | io_wr;

  io_win_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
    .wdata(cfg_wdata), .raddr(cfg_raddr), .rdata(cfg_rdata), .cfg(cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    assign ovl[w] = cfg[w].ovl;
    io_win_match u_match (
      .cfg(cfg[w]), .addr(io_addr), .access(access),
      .isa_claim(isa_claim), .eligible(elig[w]), .cs_vec(csv[w])
    );
  end

  io_win_arb #(.NUM_WIN(NUM_WIN)) u_arb (
    .eligible(elig), .ovl(ovl), .cs_vec(csv),
    .hit(win_hit), .cs(cs_sel), .conflict(conflict)
  );
endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk #(
  parameter int NUM_WIN = 2,
  parameter int NUM_CS  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               io_rd,
  input logic               io_wr,
  input logic [NUM_WIN-1:0] win_hit,
  input logic [NUM_CS-1:0]  cs_sel,
  input logic               conflict
);
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_hit)); // R9
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel)); // R7
  AST_CS_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs_sel) == (|win_hit)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd || io_wr) |-> (win_hit == '0) && !conflict); // R4
  AST_CONFLICT_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> |win_hit); // R10
endmodule

bind io_window_decoder io_window_decoder_chk #(.NUM_WIN(NUM_WIN), .NUM_CS(iowin_pkg::NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
  .win_hit(win_hit), .cs_sel(cs_sel), .conflict(conflict)
);

// File: tb/sim_io_window_decoder.sv
module sim_io_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [2:0]  cfg_raddr = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic        isa_claim = 1'b0;
  logic [1:0]  win_hit, cs_sel;
  logic        conflict;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  logic [15:0] m_base [2];
  logic [7:0]  m_size [2];
  logic [7:0]  m_ctrl [2];

  io_window_decoder u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int w, int k, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(w*4 + k); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (k)
      0: m_base[w][15:8] = d;
      1: m_base[w][7:0]  = d;
      2: m_size[w]       = d;
      default: m_ctrl[w] = d & 8'h1F;
    endcase
  endtask

  task automatic setup(int w, logic [15:0] base, logic [7:0] size, logic [7:0] ctrl);
    wr_reg(w, 0, base[15:8]);
    wr_reg(w, 1, base[7:0]);
    wr_reg(w, 2, size);
    wr_reg(w, 3, ctrl);
  endtask

  function automatic bit m_elig(int w, logic [15:0] a, bit acc, bit isa);
    logic [15:0] keep;
    bit size_ok, code_ok;
    keep    = ~{8'h00, m_size[w] - 8'h01};
    size_ok = (m_size[w] != 0) && ((m_size[w] & (m_size[w] - 8'h01)) == 0);
    code_ok = (m_ctrl[w][2:0] == 3'd5) || (m_ctrl[w][2:0] == 3'd6);
    return acc && m_ctrl[w][3] && size_ok && code_ok &&
           ((a & keep) == (m_base[w] & keep)) && (m_ctrl[w][4] || !isa);
  endfunction

  function automatic logic [4:0] m_expect(logic [15:0] a, bit acc, bit isa);
    bit e0, e1;
    logic [1:0] h, c;
    int win;
    e0 = m_elig(0, a, acc, isa);
    e1 = m_elig(1, a, acc, isa);
    h = e0 ? 2'b01 : (e1 ? 2'b10 : 2'b00);
    win = e0 ? 0 : 1;
    c = 2'b00;
    if (h != 0) c = (m_ctrl[win][2:0] == 3'd5) ? 2'b01 : 2'b10;
    return {h, c, e0 & e1 & ~m_ctrl[1][4]};
  endfunction

  // isa_mode: 0 = never, 1 = addr[0], 2 = always
  task automatic sweep(string tag, int lo, int hi, bit rd, bit wr, int isa_mode);
    for (int a = lo; a <= hi; a++) begin
      io_addr = 16'(a); io_rd = rd; io_wr = wr;
      isa_claim = (isa_mode == 2) ? 1'b1 : (isa_mode == 1) ? io_addr[0] : 1'b0;
      #1;
      check(tag, {win_hit, cs_sel, conflict},
            m_expect(io_addr, rd | wr, isa_claim));
    end
    io_rd = 0; io_wr = 0; isa_claim = 0;
  endtask

  initial begin
    for (int w = 0; w < 2; w++) begin
      m_base[w] = 16'h0000; m_size[w] = 8'h01; m_ctrl[w] = 8'h05;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values read back
    for (int i = 0; i < 8; i++) begin
      cfg_raddr = 3'(i); #1;
      check("R1 reset readback", cfg_rdata,
            (i % 4 == 2) ? 8'h01 : (i % 4 == 3) ? 8'h05 : 8'h00);
    end

    // R2: layout, unused control bits, window isolation
    wr_reg(1, 3, 8'hFF);
    wr_reg(1, 0, 8'hAB);
    wr_reg(1, 1, 8'hCD);
    wr_reg(1, 2, 8'h40);
    cfg_raddr = 3'd7; #1; check("R2 ctrl unused bits", cfg_rdata, 8'h1F);
    cfg_raddr = 3'd4; #1; check("R2 base high", cfg_rdata, 8'hAB);
    cfg_raddr = 3'd5; #1; check("R2 base low", cfg_rdata, 8'hCD);
    cfg_raddr = 3'd6; #1; check("R2 size", cfg_rdata, 8'h40);
    for (int i = 0; i < 4; i++) begin
      cfg_raddr = 3'(i); #1;
      check("R2 window0 untouched", cfg_rdata,
            (i == 2) ? 8'h01 : (i == 3) ? 8'h05 : 8'h00);
    end

    // R3: full-range sweep, single window; then a large window
    setup(1, 16'h0000, 8'h01, 8'h05);
    setup(0, 16'h0300, 8'h10, 8'h0D);
    sweep("R3 match size16", 0, 65535, 1, 0, 0);
    setup(0, 16'h12F7, 8'h80, 8'h0E);
    sweep("R3 R7 match size128 cs1", 16'h1000, 16'h1400, 0, 1, 0);

    // R4: no strobe, and disabled window
    setup(0, 16'h0300, 8'h10, 8'h1D);
    sweep("R4 no strobe", 16'h0200, 16'h0400, 0, 0, 0);
    setup(0, 16'h0300, 8'h10, 8'h15);
    sweep("R4 disabled", 16'h0200, 16'h0400, 1, 1, 0);

    // R5: bad sizes
    setup(0, 16'h0300, 8'h0C, 8'h0D);
    setup(1, 16'h0300, 8'h00, 8'h0E);
    sweep("R5 bad size", 16'h0200, 16'h0400, 1, 0, 0);

    // R6: bad codes
    setup(0, 16'h0300, 8'h10, 8'h0C);
    setup(1, 16'h0300, 8'h10, 8'h0F);
    sweep("R6 bad code", 16'h0200, 16'h0400, 1, 0, 0);

    // R8 R9 R7: overlapping windows, isa claim alternates with addr[0]
    setup(0, 16'h0300, 8'h10, 8'h0D);
    setup(1, 16'h0308, 8'h08, 8'h1E);
    sweep("R8 R9 isa yield", 16'h02F0, 16'h0320, 1, 0, 1);
    sweep("R8 isa always", 16'h02F0, 16'h0320, 1, 0, 2);

    // R10: conflict when window1 lacks overlap permit
    setup(0, 16'h0300, 8'h10, 8'h1D);
    setup(1, 16'h0308, 8'h08, 8'h0E);
    sweep("R10 conflict", 16'h02F0, 16'h0320, 0, 1, 0);
    io_addr = 16'h030A; io_rd = 1; #1;
    check("R10 directed conflict", {win_hit, cs_sel, conflict}, {2'b01, 2'b01, 1'b1});
    check("R9 directed priority", win_hit, 2'b01);
    io_rd = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule